// File: doc/BRIEF.md
# Link Mode and Turn-Around Controller

This block sets the operating state of a bidirectional 24-bit serializer/deserializer. Two frequency-select inputs choose either power-down or one of three reference-clock ranges. A direction input chooses whether the local device transmits (serializer) or receives (deserializer). From these inputs the block drives the enables for the serializer path, the deserializer path and the reference PLL. It also drives the output-enable lines of the parallel and serial pins, a power-down reset and the range code for an external PLL.

The direction input is also sent back out inverted on a purely combinational path. A master device can therefore drive the direction input of its partner with one wire, and the pair turns the link around together. Internally, the select and direction inputs pass through a synchronizer. All enables change only on clock edges, so the data paths never see a glitch.

When the block leaves power-down it first waits for the PLL to lock. The wait ends only after the reference-valid indication has been high for a set number of consecutive cycles. The data paths are enabled only after that. If the reference is lost or the range code changes, the block returns to the lock wait.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: `dir_o` equals the inverse of `dir_i` at all times, including during reset and power-down, with no clock edge needed.
- R2: When `sel_i` is 2'b00, the block settles in power-down whatever `dir_i` is. In power-down `pd_rst_o`=1, `pll_en_o`=0, `range_o`=2'b00, and all of `ser_en_o`, `des_en_o`, `ser_tx_oe_o`, `ser_rx_en_o`, `par_out_oe_o` and `wclk_hold_o` are 0.
- R3: `par_in_hold_o` and `los_arm_o` are 1 in power-down and 0 in every other state.
- R4: Outside power-down, `range_o` carries the selected code: 2'b01 for a 2–5 MHz reference, 2'b10 for 5–15 MHz, 2'b11 for 10–20 MHz.
- R5: On leaving power-down, `pll_en_o` goes to 1. No data enable rises until `ref_valid_i` has been 1 for LOCK_CYCLES consecutive cycles, and a 0 on `ref_valid_i` restarts that count.
- R6: In run state with `dir_i`=1 (serializer), `ser_en_o`=`ser_tx_oe_o`=1 and `des_en_o`=`ser_rx_en_o`=`par_out_oe_o`=0. `wclk_hold_o` is 1 whenever the block is outside power-down and `dir_i`=1.
- R7: In run state with `dir_i`=0 (deserializer), `des_en_o`=`ser_rx_en_o`=`par_out_oe_o`=1 and `ser_en_o`=`ser_tx_oe_o`=`wclk_hold_o`=0.
- R8: If `ref_valid_i` falls in run state, all data enables drop and `pll_en_o` stays 1 until the lock wait completes again.
- R9: A change of `sel_i` from one nonzero code to another drops the data enables and restarts the lock wait.
- R10: When `dir_i` toggles in run state, the enables follow after the synchronizer latency, and the serializer and deserializer enables are never both 1.
- R11: During and right after reset, the outputs take the power-down values of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Frequency select; 00 means power-down |
| dir_i | input | 1 | Direction: 1 serializer, 0 deserializer |
| ref_valid_i | input | 1 | Reference clock present and valid |
| dir_o | output | 1 | Inverted direction for the partner device |
| pd_rst_o | output | 1 | Power-down reset to internal circuitry |
| pll_en_o | output | 1 | Reference PLL enable |
| range_o | output | 2 | Reference range code for the PLL |
| los_arm_o | output | 1 | Arms loss-of-reference detection |
| par_in_hold_o | output | 1 | Forces parallel inputs to a defined level |
| ser_en_o | output | 1 | Serializer path enable |
| des_en_o | output | 1 | Deserializer path enable |
| ser_tx_oe_o | output | 1 | Serial output driver enable |
| ser_rx_en_o | output | 1 | Serial data and clock input buffer enable |
| par_out_oe_o | output | 1 | Parallel output driver enable |
| wclk_hold_o | output | 1 | Holds the word-clock output high |

## Verification
Random select codes and directions, with the reference held valid, show that each of the three range codes and power-down maps to the full, correct set of enables. They also show that a power-down code wins over either direction. Directed sequences measure the lock wait from power-down and pull the reference low halfway through it. This separates a counter that restarts from one that only pauses. Other directed cases drop the reference while running and switch between two nonzero codes, which shows that the block relocks rather than keeping stale enables. Direction toggles in run state check that the enables swap and that `dir_o` follows at once.

// File: rtl/serdes_mode_pkg.sv
package serdes_mode_pkg;

   typedef enum logic [1:0] {
      ST_PDN  = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } mode_state_t;

   localparam logic [1:0] SEL_PDN = 2'b00;

   typedef struct packed {
      logic pd_rst;
      logic pll_en;
      logic los_arm;
      logic par_in_hold;
      logic ser_en;
      logic des_en;
      logic ser_tx_oe;
      logic ser_rx_en;
      logic par_out_oe;
      logic wclk_hold;
   } ctrl_t;

   localparam ctrl_t CTRL_PDN = '{pd_rst: 1'b1, pll_en: 1'b0, los_arm: 1'b1,
                                  par_in_hold: 1'b1, default: 1'b0};

endpackage

// File: rtl/serdes_in_sync.sv
module serdes_in_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   initial begin
      if (STAGES < 2) $error("serdes_in_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("serdes_in_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/serdes_mode_decode.sv
module serdes_mode_decode
   import serdes_mode_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic             pdn_o,
   output logic [SEL_W-1:0] range_o
);

   always_comb begin
      pdn_o   = (sel_i == SEL_W'(SEL_PDN));
      range_o = pdn_o ? '0 : sel_i;
   end

endmodule

// File: rtl/serdes_lock_seq.sv
module serdes_lock_seq
   import serdes_mode_pkg::*;
#(
   parameter int SEL_W       = 2,
   parameter int LOCK_CYCLES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pdn_i,
   input  logic [SEL_W-1:0] range_i,
   input  logic             ref_valid_i,
   output mode_state_t      state_o,
   output logic [SEL_W-1:0] range_q_o
);

   localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

   initial begin
      if (LOCK_CYCLES < 2) $error("serdes_lock_seq: LOCK_CYCLES must be at least 2");
   end

   mode_state_t      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] range_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PDN;
         cnt_q   <= '0;
         range_q <= '0;
      end else if (pdn_i) begin
         state_q <= ST_PDN;
         cnt_q   <= '0;
         range_q <= '0;
      end else begin
         unique case (state_q)
            ST_PDN: begin
               state_q <= ST_WAIT;
               cnt_q   <= '0;
               range_q <= range_i;
            end
            ST_WAIT: begin
               if (range_i != range_q) begin
                  range_q <= range_i;
                  cnt_q   <= '0;
               end else if (!ref_valid_i) begin
                  cnt_q   <= '0;
               end else if (cnt_q == CNT_LAST) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
               end
            end
            ST_RUN: begin
               if (range_i != range_q || !ref_valid_i) begin
                  state_q <= ST_WAIT;
                  cnt_q   <= '0;
                  range_q <= range_i;
               end
            end
            default: begin
               state_q <= ST_PDN;
               cnt_q   <= '0;
               range_q <= '0;
            end
         endcase
      end
   end

   assign state_o   = state_q;
   assign range_q_o = range_q;

endmodule

// File: rtl/serdes_oe_gen.sv
module serdes_oe_gen
   import serdes_mode_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  mode_state_t state_i,
   input  logic        dir_i,
   output ctrl_t       ctrl_o
);

   ctrl_t nxt;

   always_comb begin
      nxt = CTRL_PDN;
      if (state_i != ST_PDN) begin
         nxt.pd_rst      = 1'b0;
         nxt.pll_en      = 1'b1;
         nxt.los_arm     = 1'b0;
         nxt.par_in_hold = 1'b0;
         nxt.wclk_hold   = dir_i;
         if (state_i == ST_RUN) begin
            nxt.ser_en     = dir_i;
            nxt.ser_tx_oe  = dir_i;
            nxt.des_en     = !dir_i;
            nxt.ser_rx_en  = !dir_i;
            nxt.par_out_oe = !dir_i;
         end
      end
   end

   if (OUT_REG) begin : g_reg
      ctrl_t ctrl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ctrl_q <= CTRL_PDN;
         else        ctrl_q <= nxt;
      end
      assign ctrl_o = ctrl_q;
   end else begin : g_comb
      assign ctrl_o = nxt;
   end

endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl
   import serdes_mode_pkg::*;
#(
   parameter int LOCK_CYCLES = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       dir_i,
   input  logic       ref_valid_i,
   output logic       dir_o,
   output logic       pd_rst_o,
   output logic       pll_en_o,
   output logic [1:0] range_o,
   output logic       los_arm_o,
   output logic       par_in_hold_o,
   output logic       ser_en_o,
   output logic       des_en_o,
   output logic       ser_tx_oe_o,
   output logic       ser_rx_en_o,
   output logic       par_out_oe_o,
   output logic       wclk_hold_o
);

   localparam int SEL_W  = 2;
   localparam int SYNC_W = SEL_W + 1;

   logic [SYNC_W-1:0] sync_q;
   logic [SEL_W-1:0]  sel_s;
   logic              dir_s;
   logic              pdn;
   logic [SEL_W-1:0]  range_dec;
   logic [SEL_W-1:0]  range_q;
   mode_state_t       state;
   ctrl_t             ctrl;
   logic [SEL_W-1:0]  range_out_q;

   // Turn-around path: inverted, no clocking
   assign dir_o = ~dir_i;

   serdes_in_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sel_i, dir_i}),
      .q_o   (sync_q)
   );

   assign sel_s = sync_q[SYNC_W-1:1];
   assign dir_s = sync_q[0];

   serdes_mode_decode #(.SEL_W(SEL_W)) i_dec (
      .sel_i   (sel_s),
      .pdn_o   (pdn),
      .range_o (range_dec)
   );

   serdes_lock_seq #(.SEL_W(SEL_W), .LOCK_CYCLES(LOCK_CYCLES)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pdn_i       (pdn),
      .range_i     (range_dec),
      .ref_valid_i (ref_valid_i),
      .state_o     (state),
      .range_q_o   (range_q)
   );

   serdes_oe_gen #(.OUT_REG(OUT_REG)) i_oe (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state),
      .dir_i   (dir_s),
      .ctrl_o  (ctrl)
   );

   if (OUT_REG) begin : g_rng_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) range_out_q <= '0;
         else        range_out_q <= (state == ST_PDN) ? '0 : range_q;
      end
   end else begin : g_rng_comb
      assign range_out_q = (state == ST_PDN) ? '0 : range_q;
   end

   assign range_o       = range_out_q;
   assign pd_rst_o      = ctrl.pd_rst;
   assign pll_en_o      = ctrl.pll_en;
   assign los_arm_o     = ctrl.los_arm;
   assign par_in_hold_o = ctrl.par_in_hold;
   assign ser_en_o      = ctrl.ser_en;
   assign des_en_o      = ctrl.des_en;
   assign ser_tx_oe_o   = ctrl.ser_tx_oe;
   assign ser_rx_en_o   = ctrl.ser_rx_en;
   assign par_out_oe_o  = ctrl.par_out_oe;
   assign wclk_hold_o   = ctrl.wclk_hold;

endmodule

// File: rtl/serdes_mode_ctrl_chk.sv
module serdes_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] sel_i,
   input logic       ref_valid_i,
   input logic       pd_rst_o,
   input logic       pll_en_o,
   input logic [1:0] range_o,
   input logic       los_arm_o,
   input logic       par_in_hold_o,
   input logic       ser_en_o,
   input logic       des_en_o,
   input logic       ser_tx_oe_o,
   input logic       ser_rx_en_o,
   input logic       par_out_oe_o,
   input logic       wclk_hold_o
);

   AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pd_rst_o |-> (!pll_en_o && !ser_tx_oe_o && !ser_rx_en_o && !par_out_oe_o && !wclk_hold_o && range_o == 2'b00)); // R2

   AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == 2'b00 && $past(sel_i) == 2'b00 && $past(sel_i, 2) == 2'b00 && $past(sel_i, 3) == 2'b00) |=> pd_rst_o); // R2

   AST_PD_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
      (los_arm_o == pd_rst_o) && (par_in_hold_o == pd_rst_o)); // R3

   AST_RANGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en_o |-> (range_o != 2'b00)); // R4

   AST_RUN_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_en_o || des_en_o) |-> $past(ref_valid_i, 2)); // R8

   AST_SER_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      ser_tx_oe_o |-> (!ser_rx_en_o && !par_out_oe_o && wclk_hold_o)); // R6

   AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ser_en_o, des_en_o})); // R10

endmodule

bind serdes_mode_ctrl serdes_mode_ctrl_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sel_i         (sel_i),
   .ref_valid_i   (ref_valid_i),
   .pd_rst_o      (pd_rst_o),
   .pll_en_o      (pll_en_o),
   .range_o       (range_o),
   .los_arm_o     (los_arm_o),
   .par_in_hold_o (par_in_hold_o),
   .ser_en_o      (ser_en_o),
   .des_en_o      (des_en_o),
   .ser_tx_oe_o   (ser_tx_oe_o),
   .ser_rx_en_o   (ser_rx_en_o),
   .par_out_oe_o  (par_out_oe_o),
   .wclk_hold_o   (wclk_hold_o)
);

// File: tb/test_serdes_mode_ctrl.sv
`timescale 1ns/1ps
module test_serdes_mode_ctrl;

   localparam int LOCK = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel_i = 2'b00;
   logic       dir_i = 1'b0;
   logic       ref_valid_i = 1'b0;
   logic       dir_o, pd_rst_o, pll_en_o, los_arm_o, par_in_hold_o;
   logic       ser_en_o, des_en_o, ser_tx_oe_o, ser_rx_en_o, par_out_oe_o, wclk_hold_o;
   logic [1:0] range_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   serdes_mode_ctrl #(.LOCK_CYCLES(LOCK)) i_serdes_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .dir_i(dir_i), .ref_valid_i(ref_valid_i),
      .dir_o(dir_o), .pd_rst_o(pd_rst_o), .pll_en_o(pll_en_o), .range_o(range_o),
      .los_arm_o(los_arm_o), .par_in_hold_o(par_in_hold_o), .ser_en_o(ser_en_o),
      .des_en_o(des_en_o), .ser_tx_oe_o(ser_tx_oe_o), .ser_rx_en_o(ser_rx_en_o),
      .par_out_oe_o(par_out_oe_o), .wclk_hold_o(wclk_hold_o)
   );

   // {pd_rst, pll_en, los_arm, par_in_hold, ser_en, des_en, ser_tx_oe, ser_rx_en, par_out_oe, wclk_hold, range}
   function automatic logic [11:0] obs();
      return {pd_rst_o, pll_en_o, los_arm_o, par_in_hold_o, ser_en_o, des_en_o,
              ser_tx_oe_o, ser_rx_en_o, par_out_oe_o, wclk_hold_o, range_o};
   endfunction

   function automatic logic [11:0] expect_vec(logic [1:0] sel, logic dir, logic run);
      if (sel == 2'b00) return 12'b1011_0000_0000;
      if (!run)         return {4'b0100, 5'b00000, dir, sel};
      return {4'b0100, dir, !dir, dir, !dir, !dir, dir, sel};
   endfunction

   task automatic check(string req, logic [11:0] act, logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic check_dir(string req);
      #1;
      n_chk++;
      if (dir_o !== ~dir_i) begin
         n_err++;
         $display("FAIL %s: actual dir_o=%b expected=%b", req, dir_o, ~dir_i);
      end
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go_pdn();
      @(negedge clk);
      sel_i = 2'b00;
      wait_cyc(8);
   endtask

   // cycles from applying sel until a data enable appears
   task automatic measure_lock(output int cyc);
      cyc = 0;
      while (!(ser_en_o || des_en_o) && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : stim
      int cyc;
      logic [1:0] s;
      logic d;
      void'($urandom(32'd1234));

      // R11 reset state and R1 during reset
      dir_i = 1'b1;
      #20;
      check("R11 reset", obs(), 12'b1011_0000_0000);
      check_dir("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(2);
      check("R11 after reset", obs(), 12'b1011_0000_0000);

      // R5 lock wait from power-down
      ref_valid_i = 1'b1;
      dir_i = 1'b1;
      sel_i = 2'b10;
      wait_cyc(5);
      check("R5 waiting pll_en", obs(), expect_vec(2'b10, 1'b1, 1'b0));
      go_pdn();
      @(negedge clk);
      sel_i = 2'b01;
      measure_lock(cyc);
      n_chk++;
      if (cyc < LOCK || cyc > LOCK + 6) begin
         n_err++;
         $display("FAIL R5 lock length: actual=%0d expected=%0d..%0d", cyc, LOCK, LOCK + 6);
      end
      check("R6 R4 serializer run", obs(), expect_vec(2'b01, 1'b1, 1'b1));

      // R5 restart: drop ref halfway
      go_pdn();
      @(negedge clk);
      sel_i = 2'b11;
      dir_i = 1'b0;
      wait_cyc(LOCK / 2 + 3);
      ref_valid_i = 1'b0;
      @(negedge clk);
      ref_valid_i = 1'b1;
      measure_lock(cyc);
      n_chk++;
      if (cyc < LOCK) begin
         n_err++;
         $display("FAIL R5 restart: actual=%0d expected>=%0d", cyc, LOCK);
      end
      check("R7 deserializer run", obs(), expect_vec(2'b11, 1'b0, 1'b1));

      // R8 loss of reference in run
      ref_valid_i = 1'b0;
      wait_cyc(4);
      check("R8 ref lost", obs(), expect_vec(2'b11, 1'b0, 1'b0));
      ref_valid_i = 1'b1;
      wait_cyc(LOCK + 6);
      check("R8 relocked", obs(), expect_vec(2'b11, 1'b0, 1'b1));

      // R9 range change while running
      sel_i = 2'b01;
      wait_cyc(5);
      check("R9 range change", obs(), expect_vec(2'b01, 1'b0, 1'b0));
      wait_cyc(LOCK + 6);
      check("R9 relock", obs(), expect_vec(2'b01, 1'b0, 1'b1));

      // R10 direction toggle in run
      dir_i = 1'b1;
      check_dir("R1 toggle");
      wait_cyc(5);
      check("R10 toggle to ser", obs(), expect_vec(2'b01, 1'b1, 1'b1));
      dir_i = 1'b0;
      check_dir("R1 toggle back");
      wait_cyc(5);
      check("R10 toggle to des", obs(), expect_vec(2'b01, 1'b0, 1'b1));

      // R2 R3 power-down with either direction
      dir_i = 1'b1;
      go_pdn();
      check("R2 R3 pdn dir1", obs(), expect_vec(2'b00, 1'b1, 1'b0));
      dir_i = 1'b0;
      wait_cyc(5);
      check("R2 R3 pdn dir0", obs(), expect_vec(2'b00, 1'b0, 1'b0));

      // random mix: R2 R4 R6 R7 R1
      for (int k = 0; k < 24; k++) begin
         s = 2'($urandom_range(0, 3));
         d = 1'($urandom_range(0, 1));
         @(negedge clk);
         sel_i = s;
         dir_i = d;
         check_dir("R1 random");
         wait_cyc(LOCK + 8);
         check("R2 R4 R6 R7 random", obs(), expect_vec(s, d, 1'b1));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule